// File: doc/BRIEF.md
# Bus Controller Retry and Polling Decision Unit

This unit sits beside the message sequencer of a dual-redundant serial data bus controller with channels A and B. After every message transaction the sequencer hands it a one-cycle outcome report. The report carries the status word the remote terminal returned, a response time-out flag, a message error flag and the channel that carried the message. From that report the unit decides what happens next. It can send the same message again, on the same channel or on the other one. It can give up on the message and report a final failure. Or it can move on to the next message, either at once or after a programmed gap counted in microsecond ticks.

Each retry cause can be switched on or off by itself: the terminal reporting busy, a message error, and no response. The number of retries per message is programmable and is capped at four. During polling, the returned status word is compared against a reference value under a per-bit mask. Any difference in the checked bits raises a one-cycle polling error event that the host interrupt logic can use.

Top module: `bc_retry_ctrl`

## Requirements
- R1: After synchronous reset, retry_go, retry_bus, advance_go, fail_evt and poll_err_evt are all low.
- R2: A report asks for a retry when at least one enabled cause is present: busy (status bit 3 set, only when no time-out is flagged, enabled by cfg_retry_busy), message error (cfg_retry_merr), or time-out (cfg_retry_tmo). A cause whose enable is low has no effect.
- R3: A message is retried at most min(cfg_retry_limit, 4) times. A report that asks for a retry once that many retries have been issued is not retried.
- R4: On a retry, retry_bus equals the reported channel (0 = A, 1 = B) when cfg_alt_bus is 0, and the other channel when cfg_alt_bus is 1.
- R5: A report that asks for a retry when no retry is left raises fail_evt for one cycle, and the unit then moves on to the next message exactly as for a clean report.
- R6: The retry count returns to zero whenever the unit moves on, so every new message again gets the full retry allowance.
- R7: With cfg_poll_en high and no time-out flagged, poll_err_evt pulses when (status XOR cfg_poll_ref) AND cfg_poll_mask is nonzero. It stays low when the masked bits agree, when polling is disabled, or when a time-out is flagged.
- R8: With cfg_gap_en high and cfg_gap_us nonzero, advance_go pulses in the cycle after the cfg_gap_us-th tick_us pulse that follows the report. Otherwise it pulses in the cycle after the report.
- R9: Outcome reports that arrive while a gap is being timed are ignored: they cause no retry, no fail, no poll error and no early advance.
- R10: retry_go, fail_evt and poll_err_evt are single-cycle pulses in the cycle right after the report. retry_go and advance_go are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_us | input | 1 | One-cycle pulse every microsecond |
| cfg_retry_busy | input | 1 | Enable retry on terminal busy |
| cfg_retry_merr | input | 1 | Enable retry on message error |
| cfg_retry_tmo | input | 1 | Enable retry on response time-out |
| cfg_alt_bus | input | 1 | Retry on the other channel when high |
| cfg_retry_limit | input | 3 | Requested retries per message (capped at 4) |
| cfg_poll_en | input | 1 | Enable polling compare |
| cfg_poll_ref | input | 16 | Expected status word |
| cfg_poll_mask | input | 16 | Status bits that take part in the compare |
| cfg_gap_en | input | 1 | Enable intermessage gap |
| cfg_gap_us | input | 16 | Gap length in microsecond ticks |
| done_vld | input | 1 | Outcome report strobe |
| done_sts | input | 16 | Returned status word |
| done_tmo | input | 1 | No response from terminal |
| done_merr | input | 1 | Message error detected |
| done_bus | input | 1 | Channel used, 0 = A, 1 = B |
| retry_go | output | 1 | Resend current message |
| retry_bus | output | 1 | Channel for the resend |
| advance_go | output | 1 | Start next message |
| fail_evt | output | 1 | Retries exhausted for this message |
| poll_err_evt | output | 1 | Masked status mismatch |

## Verification
The decision path gets reports with each retry cause alone, with each cause present but its enable low, and with a busy bit next to a time-out flag. Together these show whether every cause is gated by its own enable and whether a status word is trusted after a time-out. Runs of repeated failing reports with limits 0, 1, 4 and 7 separate a correct count and cap from an off-by-one or an unclamped limit. A following message then shows whether the count was cleared. Status words that differ only in masked-out bits, in checked bits, or that arrive with a time-out tell the mask apart from a plain compare. Gap runs of several ticks, with a stray report in the middle and a zero length, pin down the advance cycle.

// File: rtl/bc_retry_pkg.sv
package bc_retry_pkg;

    localparam int STS_W    = 16;
    localparam int BUSY_BIT = 3;

    typedef enum logic [1:0] {
        ACT_ADVANCE = 2'd0,
        ACT_RETRY   = 2'd1,
        ACT_FAIL    = 2'd2
    } action_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_GAP  = 1'b1
    } phase_e;

    typedef struct packed {
        logic [STS_W-1:0] sts;
        logic             tmo;
        logic             merr;
        logic             bus;
    } outcome_t;

    typedef struct packed {
        logic on_busy;
        logic on_merr;
        logic on_tmo;
        logic alt_bus;
    } retry_cfg_t;

    function automatic logic pick_bus(input logic used, input logic alt);
        return alt ? ~used : used;
    endfunction

endpackage

// File: rtl/bc_poll_cmp.sv
module bc_poll_cmp
    import bc_retry_pkg::*;
#(
    parameter int W = STS_W
) (
    input  logic         enable,
    input  logic         no_reply,
    input  logic [W-1:0] sts,
    input  logic [W-1:0] ref_word,
    input  logic [W-1:0] mask,
    output logic         mismatch
);
    logic [W-1:0] diff;

    always_comb begin
        diff     = (sts ^ ref_word) & mask;
        mismatch = enable && !no_reply && (diff != '0);
    end
endmodule

// File: rtl/bc_retry_decide.sv
module bc_retry_decide
    import bc_retry_pkg::*;
#(
    parameter int MAX_RETRY = 4,
    parameter int RW        = 3
) (
    input  outcome_t     res,
    input  retry_cfg_t   cfg,
    input  logic [RW-1:0] limit_req,
    input  logic [RW-1:0] tries,
    output action_e      act
);
    localparam logic [RW-1:0] CAP = RW'(MAX_RETRY);

    logic          want;
    logic [RW-1:0] limit;

    always_comb begin
        limit = (limit_req > CAP) ? CAP : limit_req;
        want  = (cfg.on_busy && !res.tmo && res.sts[BUSY_BIT])
              | (cfg.on_merr && res.merr)
              | (cfg.on_tmo  && res.tmo);
        if (!want)
            act = ACT_ADVANCE;
        else if (tries < limit)
            act = ACT_RETRY;
        else
            act = ACT_FAIL;
    end
endmodule

// File: rtl/bc_gap_timer.sv
module bc_gap_timer #(
    parameter int GW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [GW-1:0] load_val,
    input  logic          tick,
    output logic          expire
);
    logic [GW-1:0] remain;
    logic          running;

    assign expire = running && tick && (remain == GW'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            remain  <= '0;
            running <= 1'b0;
        end else if (load) begin
            remain  <= load_val;
            running <= (load_val != '0);
        end else if (running && tick) begin
            remain <= remain - GW'(1);
            if (remain == GW'(1))
                running <= 1'b0;
        end
    end
endmodule

// File: rtl/bc_retry_ctrl.sv
module bc_retry_ctrl
    import bc_retry_pkg::*;
#(
    parameter int MAX_RETRY = 4,
    parameter int RW        = 3,
    parameter int GW        = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick_us,
    input  logic          cfg_retry_busy,
    input  logic          cfg_retry_merr,
    input  logic          cfg_retry_tmo,
    input  logic          cfg_alt_bus,
    input  logic [RW-1:0] cfg_retry_limit,
    input  logic          cfg_poll_en,
    input  logic [15:0]   cfg_poll_ref,
    input  logic [15:0]   cfg_poll_mask,
    input  logic          cfg_gap_en,
    input  logic [GW-1:0] cfg_gap_us,
    input  logic          done_vld,
    input  logic [15:0]   done_sts,
    input  logic          done_tmo,
    input  logic          done_merr,
    input  logic          done_bus,
    output logic          retry_go,
    output logic          retry_bus,
    output logic          advance_go,
    output logic          fail_evt,
    output logic          poll_err_evt
);
    outcome_t      res;
    retry_cfg_t    rcfg;
    action_e       act;
    phase_e        phase;
    logic [RW-1:0] tries;
    logic          mismatch;
    logic          accept;
    logic          moving_on;
    logic          gap_load;
    logic          gap_expire;

    always_comb begin
        res       = '{sts: done_sts, tmo: done_tmo, merr: done_merr, bus: done_bus};
        rcfg      = '{on_busy: cfg_retry_busy, on_merr: cfg_retry_merr,
                      on_tmo: cfg_retry_tmo, alt_bus: cfg_alt_bus};
        accept    = done_vld && (phase == ST_IDLE);
        moving_on = accept && (act != ACT_RETRY);
        gap_load  = moving_on && cfg_gap_en && (cfg_gap_us != '0);
    end

    bc_poll_cmp #(.W(16)) u_cmp (
        .enable   (cfg_poll_en),
        .no_reply (done_tmo),
        .sts      (done_sts),
        .ref_word (cfg_poll_ref),
        .mask     (cfg_poll_mask),
        .mismatch (mismatch)
    );

    bc_retry_decide #(.MAX_RETRY(MAX_RETRY), .RW(RW)) u_dec (
        .res       (res),
        .cfg       (rcfg),
        .limit_req (cfg_retry_limit),
        .tries     (tries),
        .act       (act)
    );

    bc_gap_timer #(.GW(GW)) u_gap (
        .clk      (clk),
        .rst      (rst),
        .load     (gap_load),
        .load_val (cfg_gap_us),
        .tick     (tick_us),
        .expire   (gap_expire)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase        <= ST_IDLE;
            tries        <= '0;
            retry_go     <= 1'b0;
            retry_bus    <= 1'b0;
            advance_go   <= 1'b0;
            fail_evt     <= 1'b0;
            poll_err_evt <= 1'b0;
        end else begin
            retry_go     <= 1'b0;
            advance_go   <= 1'b0;
            fail_evt     <= 1'b0;
            poll_err_evt <= accept && mismatch;
            if (accept) begin
                if (act == ACT_RETRY) begin
                    retry_go  <= 1'b1;
                    retry_bus <= pick_bus(done_bus, cfg_alt_bus);
                    tries     <= tries + RW'(1);
                end else begin
                    fail_evt <= (act == ACT_FAIL);
                    tries    <= '0;
                    if (gap_load)
                        phase <= ST_GAP;
                    else
                        advance_go <= 1'b1;
                end
            end else if (phase == ST_GAP && gap_expire) begin
                phase      <= ST_IDLE;
                advance_go <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/bc_retry_chk.sv
module bc_retry_chk #(
    parameter int MAX_RETRY = 4
) (
    input logic clk,
    input logic rst,
    input logic done_vld,
    input logic done_tmo,
    input logic done_bus,
    input logic cfg_alt_bus,
    input logic retry_go,
    input logic retry_bus,
    input logic advance_go,
    input logic fail_evt,
    input logic poll_err_evt
);
    logic [3:0] seen;

    always_ff @(posedge clk) begin
        if (rst || advance_go)
            seen <= '0;
        else if (retry_go && seen != 4'hF)
            seen <= seen + 4'd1;
    end

    p_retry_cap_r3: assert property (@(posedge clk) disable iff (rst)
        retry_go |-> (32'(seen) < MAX_RETRY));

    p_same_bus_r4: assert property (@(posedge clk) disable iff (rst)
        (retry_go && !$past(cfg_alt_bus)) |-> (retry_bus == $past(done_bus)));

    p_alt_bus_r4: assert property (@(posedge clk) disable iff (rst)
        (retry_go && $past(cfg_alt_bus)) |-> (retry_bus != $past(done_bus)));

    p_fail_no_retry_r5: assert property (@(posedge clk) disable iff (rst)
        fail_evt |-> !retry_go);

    p_tmo_no_poll_r7: assert property (@(posedge clk) disable iff (rst)
        poll_err_evt |-> ($past(done_vld) && !$past(done_tmo)));

    p_retry_after_report_r10: assert property (@(posedge clk) disable iff (rst)
        retry_go |-> $past(done_vld));

    p_exclusive_r10: assert property (@(posedge clk) disable iff (rst)
        $onehot0({retry_go, advance_go}));
endmodule

bind bc_retry_ctrl bc_retry_chk #(.MAX_RETRY(MAX_RETRY)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .done_vld     (done_vld),
    .done_tmo     (done_tmo),
    .done_bus     (done_bus),
    .cfg_alt_bus  (cfg_alt_bus),
    .retry_go     (retry_go),
    .retry_bus    (retry_bus),
    .advance_go   (advance_go),
    .fail_evt     (fail_evt),
    .poll_err_evt (poll_err_evt)
);

// File: tb/bc_retry_ctrl_test.sv
module bc_retry_ctrl_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_us = 1'b0;
    logic        cfg_retry_busy, cfg_retry_merr, cfg_retry_tmo, cfg_alt_bus;
    logic [2:0]  cfg_retry_limit;
    logic        cfg_poll_en, cfg_gap_en;
    logic [15:0] cfg_poll_ref, cfg_poll_mask, cfg_gap_us;
    logic        done_vld = 1'b0, done_tmo = 1'b0, done_merr = 1'b0, done_bus = 1'b0;
    logic [15:0] done_sts = '0;
    logic        retry_go, retry_bus, advance_go, fail_evt, poll_err_evt;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    bc_retry_ctrl uut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic defaults();
        cfg_retry_busy = 1; cfg_retry_merr = 1; cfg_retry_tmo = 1; cfg_alt_bus = 0;
        cfg_retry_limit = 3'd4; cfg_poll_en = 0; cfg_poll_ref = '0; cfg_poll_mask = '0;
        cfg_gap_en = 0; cfg_gap_us = '0;
    endtask

    // drive one report, then sample outputs produced by the edge that took it
    task automatic report(input logic [15:0] sts, input logic tmo, input logic merr, input logic bus);
        @(negedge clk);
        done_sts = sts; done_tmo = tmo; done_merr = merr; done_bus = bus; done_vld = 1;
        @(negedge clk);
        done_vld = 0; done_tmo = 0; done_merr = 0;
    endtask

    task automatic tick();
        @(negedge clk); tick_us = 1;
        @(negedge clk); tick_us = 0;
    endtask

    task automatic expect_outs(input string req, input logic r, input logic a, input logic f);
        chk({req, " retry_go"}, 32'(retry_go), 32'(r));
        chk({req, " advance_go"}, 32'(advance_go), 32'(a));
        chk({req, " fail_evt"}, 32'(fail_evt), 32'(f));
    endtask

    task automatic t_reset();
        chk("R1 reset outputs", {27'd0, retry_go, retry_bus, advance_go, fail_evt, poll_err_evt}, 32'd0);
    endtask

    task automatic t_clean();
        defaults();
        report(16'h0800, 0, 0, 0);
        expect_outs("R8 clean no gap", 0, 1, 0);
        @(negedge clk);
        chk("R10 advance single pulse", 32'(advance_go), 32'd0);
    endtask

    task automatic t_enables();
        defaults();
        cfg_retry_busy = 0;
        report(16'h0008, 0, 0, 0);
        expect_outs("R2 busy disabled", 0, 1, 0);
        cfg_retry_busy = 1; cfg_retry_tmo = 0;
        report(16'h0008, 1, 0, 0);
        expect_outs("R2 busy ignored on timeout", 0, 1, 0);
        cfg_retry_merr = 0;
        report(16'h0000, 0, 1, 0);
        expect_outs("R2 merr disabled", 0, 1, 0);
        cfg_retry_merr = 1;
        report(16'h0000, 0, 1, 0);
        expect_outs("R2 merr enabled", 1, 0, 0);
        @(negedge clk);
        chk("R10 retry single pulse", 32'(retry_go), 32'd0);
        cfg_retry_tmo = 1;
        report(16'h0000, 1, 0, 0);
        expect_outs("R2 tmo enabled", 1, 0, 0);
        report(16'h0000, 0, 0, 0);
        expect_outs("R2 finish message", 0, 1, 0);
    endtask

    task automatic run_limit(input string req, input logic [2:0] lim, input int n_exp);
        defaults();
        cfg_retry_limit = lim;
        for (int i = 0; i < n_exp; i++) begin
            report(16'h0008, 0, 0, 1);
            expect_outs({req, " retry step"}, 1, 0, 0);
            chk({req, " same bus R4"}, 32'(retry_bus), 32'd1);
        end
        report(16'h0008, 0, 0, 1);
        expect_outs({req, " exhausted R5"}, 0, 1, 1);
    endtask

    task automatic t_limits();
        run_limit("R3 limit4", 3'd4, 4);
        report(16'h0008, 0, 0, 0);
        expect_outs("R6 count cleared", 1, 0, 0);
        report(16'h0000, 0, 0, 0);
        expect_outs("R6 finish", 0, 1, 0);
        run_limit("R3 limit7 clamps", 3'd7, 4);
        run_limit("R3 limit1", 3'd1, 1);
        run_limit("R3 limit0", 3'd0, 0);
    endtask

    task automatic t_alt();
        defaults();
        cfg_alt_bus = 1;
        report(16'h0000, 0, 1, 0);
        chk("R4 alt from A", {31'd0, retry_go & retry_bus}, 32'd1);
        report(16'h0000, 0, 1, 1);
        chk("R4 alt from B", {30'd0, retry_go, retry_bus}, 32'd2);
        report(16'h0000, 0, 0, 0);
        expect_outs("R4 finish", 0, 1, 0);
    endtask

    task automatic t_poll();
        defaults();
        cfg_poll_en = 1; cfg_poll_ref = 16'h0800; cfg_poll_mask = 16'hF800; cfg_retry_busy = 0;
        report(16'h0808, 0, 0, 0);
        chk("R7 masked bits agree", 32'(poll_err_evt), 32'd0);
        report(16'h1000, 0, 0, 0);
        chk("R7 checked bit differs", 32'(poll_err_evt), 32'd1);
        @(negedge clk);
        chk("R10 poll pulse ends", 32'(poll_err_evt), 32'd0);
        cfg_retry_tmo = 0;
        report(16'h1000, 1, 0, 0);
        chk("R7 timeout suppresses", 32'(poll_err_evt), 32'd0);
        cfg_poll_en = 0;
        report(16'h1000, 0, 0, 0);
        chk("R7 polling disabled", 32'(poll_err_evt), 32'd0);
    endtask

    task automatic t_gap();
        defaults();
        cfg_gap_en = 1; cfg_gap_us = 16'd3; cfg_poll_en = 1; cfg_poll_mask = 16'hFFFF;
        report(16'h0000, 0, 0, 0);
        chk("R8 no advance before ticks", 32'(advance_go), 32'd0);
        tick();
        chk("R8 after tick1", 32'(advance_go), 32'd0);
        report(16'h0008, 0, 1, 0);
        chk("R9 report in gap ignored", {29'd0, retry_go, fail_evt, poll_err_evt}, 32'd0);
        tick();
        chk("R8 after tick2", 32'(advance_go), 32'd0);
        tick();
        chk("R8 after tick3", 32'(advance_go), 32'd1);
        @(negedge clk);
        chk("R8 advance single pulse", 32'(advance_go), 32'd0);
        cfg_gap_us = 16'd0; cfg_poll_en = 0;
        report(16'h0000, 0, 0, 0);
        chk("R8 zero gap immediate", 32'(advance_go), 32'd1);
    endtask

    initial begin
        defaults();
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_clean();
        t_enables();
        t_limits();
        t_alt();
        t_poll();
        t_gap();
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule